// File: doc/BRIEF.md
# Bank-Typed Packed Add/Subtract Unit

This unit performs SIMD addition and subtraction on a 32-bit word. The instruction does not encode the element type. The number of the destination register sets it instead. That index chooses between four 8-bit lanes and two 16-bit lanes, and it also chooses signed or unsigned treatment. A 2-bit mode field chooses between wrapping and saturating arithmetic. Halving forms of add and subtract average the two operands without overflow.

Each lane is computed on its own, and no carry crosses a lane boundary. The packed result and two flags are captured one clock after a valid strobe. One flag reports that at least one lane was clamped. The other reports a destination or mode that the unit cannot execute.

Top module: `pk_addsub`

## Requirements
- R1: The destination index selects the bank, as follows:
  - 2..7: four signed 8-bit lanes.
  - 8..15: four unsigned 8-bit lanes.
  - 16..23: two signed 16-bit lanes.
  - 24..29: two unsigned 16-bit lanes.
  - Lane k occupies bits [W*k+W-1 : W*k], with lane 0 at the least significant end.
- R2: The operation select is encoded as follows: 00 add, 01 subtract (a minus b), 10 halving add, 11 halving subtract. Mode 00 wraps and mode 01 saturates.
- R3: With mode 00, add and subtract wrap modulo 2^W in each lane, in the same way for signed and unsigned banks. Carries never cross lanes, and the saturation flag stays 0.
- R4: With mode 01 on a signed bank, each lane clamps to the range -2^(W-1) .. 2^(W-1)-1.
- R5: With mode 01 on an unsigned bank, each lane clamps to the range 0 .. 2^W-1.
- R6: The saturation flag is 1 exactly when at least one lane was clamped.
- R7: Halving operations form the sum or difference at W+1 bits and then take floor(x/2). The operands are sign-extended on a signed bank and zero-extended on an unsigned bank. The saturation flag is 0 for halving operations.
- R8: The illegal flag is 1 in any of these cases:
  - destination 1, 30 or 31;
  - mode 10 or 11;
  - a halving operation with mode 01.

  When the illegal flag is 1, the result is 0 and the saturation flag is 0.
- R9: Destination 0 gives a result of 0 with both flags at 0.
- R10: The outputs update on the clock edge after a cycle in which in_valid is high, and out_valid is high for exactly that cycle. Without in_valid, the result and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Operation select |
| mode | input | 2 | Wrap/saturate mode |
| dest | input | 5 | Destination register index |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Packed result |
| out_sat | output | 1 | Some lane clamped |
| out_illegal | output | 1 | Illegal destination or mode |

## Verification
The hardest cases to reach are those where one lane overflows and its neighbour sits exactly at a limit. Only these cases show whether a clamp or a carry leaks across the boundary, and random operands seldom produce them. Directed vectors therefore place limit values (0x7F/0x80, 0xFF/0x00, 0x7FFF/0x8000) in adjacent lanes of every bank. Random traffic over all destinations and modes then covers the rest. A behavioural integer model is compared on every operation.

// File: rtl/pk_pkg.sv
package pk_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_HADD = 2'b10,
    OP_HSUB = 2'b11
  } pk_op_e;

  localparam logic [1:0] MODE_WRAP = 2'b00;
  localparam logic [1:0] MODE_SAT  = 2'b01;

  typedef struct packed {
    logic wide;
    logic sgn;
    logic illegal;
    logic zero;
  } pk_bank_t;
endpackage

// File: rtl/pk_bank_decode.sv
module pk_bank_decode
  import pk_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] dest,
  input  logic [1:0]    op,
  input  logic [1:0]    mode,
  output pk_bank_t      bank
);
  always_comb begin
    bank.zero    = (dest == '0);
    bank.wide    = (dest >= IW'(16));
    bank.sgn     = ((dest >= IW'(2)) && (dest <= IW'(7))) ||
                   ((dest >= IW'(16)) && (dest <= IW'(23)));
    bank.illegal = (dest == IW'(1)) || (dest >= IW'(30)) || mode[1] ||
                   (op[1] && (mode == MODE_SAT));
  end
endmodule

// File: rtl/pk_lane.sv
module pk_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         half,
  input  logic         sat_en,
  input  logic         sgn,
  output logic [W-1:0] res,
  output logic         clamped
);
  localparam int EW = W + 2;
  logic [EW-1:0] ea, eb, s;

  always_comb begin
    ea = {{2{sgn & a[W-1]}}, a};
    eb = {{2{sgn & b[W-1]}}, b};
    s  = sub ? (ea - eb) : (ea + eb);
    clamped = 1'b0;
    res     = s[W-1:0];
    if (half) begin
      res = s[W:1];
    end else if (sat_en) begin
      if (sgn) begin
        if (s[W] != s[W-1]) begin
          clamped = 1'b1;
          res = s[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      end else if (s[W+1]) begin
        clamped = 1'b1;
        res = '0;
      end else if (s[W]) begin
        clamped = 1'b1;
        res = '1;
      end
    end
  end
endmodule

// File: rtl/pk_addsub.sv
module pk_addsub
  import pk_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic [1:0]    mode,
  input  logic [IW-1:0] dest,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_sat,
  output logic          out_illegal
);
  localparam int N8  = DW / 8;
  localparam int N16 = DW / 16;

  logic [1:0] rst_sync;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  pk_bank_t bank;
  pk_bank_decode #(.IW(IW)) u_dec (.dest(dest), .op(op), .mode(mode), .bank(bank));

  logic sat_en;
  assign sat_en = (mode == MODE_SAT);

  logic [DW-1:0]  r8, r16;
  logic [N8-1:0]  c8;
  logic [N16-1:0] c16;

  for (genvar k = 0; k < N8; k++) begin : g_l8
    pk_lane #(.W(8)) u_lane (
      .a(src_a[8*k +: 8]), .b(src_b[8*k +: 8]), .sub(op[0]), .half(op[1]),
      .sat_en(sat_en), .sgn(bank.sgn), .res(r8[8*k +: 8]), .clamped(c8[k]));
  end
  for (genvar k = 0; k < N16; k++) begin : g_l16
    pk_lane #(.W(16)) u_lane (
      .a(src_a[16*k +: 16]), .b(src_b[16*k +: 16]), .sub(op[0]), .half(op[1]),
      .sat_en(sat_en), .sgn(bank.sgn), .res(r16[16*k +: 16]), .clamped(c16[k]));
  end

  logic [DW-1:0] res_d;
  logic          sat_d, ill_d, vld_d;
  always_comb begin
    vld_d = in_valid;
    ill_d = bank.illegal;
    if (bank.illegal || bank.zero) begin
      res_d = '0;
      sat_d = 1'b0;
    end else if (bank.wide) begin
      res_d = r16;
      sat_d = |c16;
    end else begin
      res_d = r8;
      sat_d = |c8;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_sat     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= vld_d;
      if (in_valid) begin
        out_result  <= res_d;
        out_sat     <= sat_d;
        out_illegal <= ill_d;
      end
    end
  end

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    out_illegal |-> (out_result == '0) && !out_sat); // R8
  AST_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && mode[1]) |=> out_illegal); // R8
  AST_WRAP_NO_SAT: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && mode == MODE_WRAP) |=> !out_sat); // R3
  AST_HALF_NO_SAT: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && op[1]) |=> !out_sat); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid && $stable(out_result) && $stable(out_sat)); // R10
endmodule

// File: tb/test_pk_addsub.sv
module test_pk_addsub;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0, mode = '0;
  logic [4:0]  dest = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        out_valid, out_sat, out_illegal;
  logic [31:0] out_result;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pk_addsub i_pk_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .mode(mode),
    .dest(dest), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_result(out_result), .out_sat(out_sat), .out_illegal(out_illegal));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] o, input logic [1:0] m, input logic [4:0] d,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic s, output logic il,
                       output string tag);
    int w, n, x, y, v, lo, hi, msk;
    bit sg;
    il = (d == 1) || (d >= 30) || m[1] || (o[1] && m == 2'b01);
    r = '0; s = 1'b0;
    if (il) begin tag = "R8"; return; end
    if (d == 0) begin tag = "R9"; return; end
    w  = (d < 16) ? 8 : 16;
    sg = (d < 8) || (d >= 16 && d < 24);
    n  = 32 / w;
    msk = (1 << w) - 1;
    tag = o[1] ? "R7 R1 R2" : (m == 2'b01 ? (sg ? "R4 R6 R1 R2" : "R5 R6 R1 R2") : "R3 R1 R2");
    for (int k = 0; k < n; k++) begin
      x = (a >> (w*k)) & msk;
      y = (b >> (w*k)) & msk;
      if (sg && x >= (1 << (w-1))) x -= (1 << w);
      if (sg && y >= (1 << (w-1))) y -= (1 << w);
      v = o[0] ? x - y : x + y;
      if (o[1]) v = v >>> 1;
      else if (m == 2'b01) begin
        lo = sg ? -(1 << (w-1)) : 0;
        hi = sg ? (1 << (w-1)) - 1 : msk;
        if (v < lo) begin v = lo; s = 1'b1; end
        if (v > hi) begin v = hi; s = 1'b1; end
      end
      r |= (32'(v & msk)) << (w*k);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [1:0] m, input logic [4:0] d,
                     input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er; logic es, ei; string tag;
    model(o, m, d, a, b, er, es, ei, tag);
    @(negedge clk);
    op = o; mode = m; dest = d; src_a = a; src_b = b; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk({tag, " R10 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " result"}, 64'(out_result), 64'(er));
    chk({tag, " sat"}, 64'(out_sat), 64'(es));
    chk({tag, " illegal"}, 64'(out_illegal), 64'(ei));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hr; logic hs, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset R10 valid", 64'(out_valid), 64'd0);
    chk("reset result", 64'(out_result), 64'd0);
    chk("reset flags", 64'({out_sat, out_illegal}), 64'd0);

    // R3 wrap, no carry across lanes
    run(2'b00, 2'b00, 5'd9,  32'hFF01_FF80, 32'h0101_0180);
    run(2'b01, 2'b00, 5'd3,  32'h0080_0000, 32'h0001_0001);
    run(2'b00, 2'b00, 5'd20, 32'hFFFF_7FFF, 32'h0001_0001);
    // R4 signed clamp, neighbouring lanes at limits
    run(2'b00, 2'b01, 5'd4,  32'h7F80_7F01, 32'h0100_FF01);
    run(2'b01, 2'b01, 5'd7,  32'h8000_7F00, 32'h0100_FF00);
    run(2'b00, 2'b01, 5'd16, 32'h7FFF_8000, 32'h0001_FFFF);
    run(2'b00, 2'b01, 5'd17, 32'h7FFE_0005, 32'h0001_0003);
    // R5 unsigned clamp
    run(2'b00, 2'b01, 5'd12, 32'hFF00_FE01, 32'h0100_01FF);
    run(2'b01, 2'b01, 5'd8,  32'h0000_0500, 32'h0100_0301);
    run(2'b01, 2'b01, 5'd29, 32'h0000_FFFF, 32'h0001_FFFF);
    run(2'b00, 2'b01, 5'd24, 32'hFFFF_0001, 32'h0001_0001);
    // R7 halving
    run(2'b10, 2'b00, 5'd2,  32'h7F80_FF01, 32'h7F80_0002);
    run(2'b11, 2'b00, 5'd5,  32'h0080_0001, 32'h7F7F_0002);
    run(2'b10, 2'b00, 5'd15, 32'hFFFF_0001, 32'hFF01_0002);
    run(2'b11, 2'b00, 5'd26, 32'h0000_0003, 32'hFFFF_0000);
    run(2'b10, 2'b00, 5'd23, 32'h8000_7FFF, 32'h8000_7FFF);
    // R8 illegal
    run(2'b00, 2'b00, 5'd1,  32'h1234_5678, 32'h1111_1111);
    run(2'b00, 2'b00, 5'd30, 32'h7FFF_7FFF, 32'h0001_0001);
    run(2'b00, 2'b01, 5'd31, 32'h7FFF_7FFF, 32'h0001_0001);
    run(2'b00, 2'b10, 5'd4,  32'h7F7F_7F7F, 32'h0101_0101);
    run(2'b01, 2'b11, 5'd20, 32'h1, 32'h2);
    run(2'b10, 2'b01, 5'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9 zero destination
    run(2'b00, 2'b01, 5'd0,  32'h7F7F_7F7F, 32'h0101_0101);

    // R10 hold without valid
    run(2'b00, 2'b01, 5'd4, 32'h7F00_0000, 32'h0100_0000);
    hr = out_result; hs = out_sat; hi = out_illegal;
    @(negedge clk);
    op = 2'b01; mode = 2'b10; dest = 5'd1; src_a = 32'h5; src_b = 32'h9;
    @(posedge clk); #1;
    chk("R10 no valid", 64'(out_valid), 64'd0);
    chk("R10 hold result", 64'(out_result), 64'(hr));
    chk("R10 hold flags", 64'({out_sat, out_illegal}), 64'({hs, hi}));

    for (int i = 0; i < 600; i++)
      run(2'($urandom), 2'($urandom_range(0, 2) == 2 ? $urandom : $urandom_range(0, 1)),
          5'($urandom), $urandom, $urandom);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule